// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the external bus front end of a small 8-bit processor core with a 16-bit address space. The core hands it one request at a time: a cycle kind, an address and, for writes, a data byte. The controller then runs a fixed three-clock machine cycle on the pins. During the first clock the low address byte goes out on a shared set of data lines and an address-latch-enable pulse marks it. During the second and third clocks the same lines carry write data, or are released so that read data can come back. The upper address byte has its own output-only lines. A three-bit status code on the memory/IO select and two status lines identifies the kind of cycle. One active-low strobe (read, write or interrupt acknowledge) is asserted for the data phase.

Every pin that can float is presented as a value plus an output-enable, so that the pad ring builds the tristate buffer. Outside a machine cycle, the controller obeys three conditions: bus hold, halt and reset. Each floats its own set of outputs. A cycle already in progress always finishes before hold or halt takes the bus. A synchronous reset aborts the cycle at once.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: A request is accepted on a clock edge only when the controller is idle, not in hold or halt, and neither hold_req nor halt_req is high. The accepted cycle occupies exactly three clocks, T1, T2 and T3, and busy is high in all three. ale is high in T1 only. After T3 there is always one idle clock before the next T1.
- R2: In T1, ad_oe is 1 and ad_out carries address bits 7:0.
- R3: The status triple {iom, s1, s0} is 011 for opcode fetch, 010 for memory read, 001 for memory write, 110 for I/O read, 101 for I/O write and 111 for interrupt acknowledge. req_kind uses the same three-bit codes. The triple is driven with iom_oe = 1 from T1 to T3, and it keeps the last cycle's code while idle (000 after reset).
- R4: In T2 and T3, rd_n is 0 for fetch, memory read and I/O read. wr_n is 0 for memory write and I/O write. inta_n is 0 only for interrupt acknowledge. All strobes are 1 in T1 and outside cycles.
- R5: In write cycles, ad_oe is 1 and ad_out carries the write data in T2 and T3. In read-type cycles (fetch, memory read, I/O read, interrupt acknowledge), ad_oe is 0 in T2 and T3. ad_in is captured at the edge that ends T3 and appears on rdata, with rdata_valid high for the single following clock.
- R6: addr_hi is output-only. It carries address bits 15:8 with addr_hi_oe = 1 during cycles and while idle.
- R7: In hold, iom_oe, ctl_oe (which enables rd_n and wr_n), addr_hi_oe and ad_oe are 0, inta_n is 1, {s1,s0} is 00, and requests are ignored.
- R8: In halt, iom_oe, addr_hi_oe and ad_oe are 0, {s1,s0} is 00, and rd_n and wr_n are driven high with ctl_oe = 1.
- R9: While reset is applied (synchronous, active low), inta_n is 1 and iom_oe, addr_hi_oe, ad_oe, ctl_oe, busy and ale are 0. A cycle in progress is abandoned.
- R10: hold_req and halt_req take effect only from idle. A cycle in progress completes all three clocks. When both are high, hold wins.
- R11: Requests with req_kind 000 or 100 are ignored: no ale and no busy follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A cycle request is presented |
| req_kind | input | 3 | Cycle kind, coded as its status triple |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| hold_req | input | 1 | Bus hold request |
| halt_req | input | 1 | Halt condition |
| ad_in | input | 8 | Shared lines as seen from the pad |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Enable for the shared lines |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Enable for the upper address |
| ale | output | 1 | Address latch enable |
| iom | output | 1 | Memory/IO select status |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| iom_oe | output | 1 | Enable for iom |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Enable for rd_n and wr_n |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| busy | output | 1 | A machine cycle is in progress |
| rdata | output | 8 | Last captured read data |
| rdata_valid | output | 1 | rdata was captured at the previous edge |

## Verification
The bench raises hold in the first clock of a fetch. A controller that grabbed the bus at once would float the read strobe in T2 instead of finishing the cycle. It holds a write request valid across several cycles to expose a missing idle slot or a double accept. It also offers requests with the two unused kind codes and during hold, which a loose accept condition would turn into an ale pulse. Hold and halt are raised together to catch inverted priority, which would leave the read/write strobes driven. Reset is applied in T2 of a write to show that the write data and strobe are dropped at once rather than held to T3.

// File: rtl/bcc_pkg.sv
// Shared types for the bus cycle controller.
// Cycle kinds are coded directly as the status triple {iom, s1, s0}.
package bcc_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'b000,
        K_MWR   = 3'b001,
        K_MRD   = 3'b010,
        K_FETCH = 3'b011,
        K_BAD   = 3'b100,
        K_IOWR  = 3'b101,
        K_IORD  = 3'b110,
        K_INTA  = 3'b111
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_HOLD,
        PH_HALT,
        PH_RST
    } phase_e;

    // True for the six codes that name a real machine cycle.
    function automatic logic kind_ok(input logic [2:0] k);
        return (k != K_NONE) && (k != K_BAD);
    endfunction

    // True when the cycle takes data from the bus.
    function automatic logic kind_reads(input logic [2:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD) || (k == K_INTA);
    endfunction

    // True when the cycle pulses the read strobe.
    function automatic logic kind_rd_strobe(input logic [2:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    // True when the cycle drives write data.
    function automatic logic kind_writes(input logic [2:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

endpackage

// File: rtl/bcc_sequencer.sv
// Phase sequencer: steps a three-clock machine cycle and parks the bus in
// idle, hold, halt or reset between cycles.
// Assumes: hold and halt are sampled only between cycles; synchronous
// active-low reset forces the reset phase immediately.
module bcc_sequencer
    import bcc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [2:0]   req_kind,
    input  logic         hold_req,
    input  logic         halt_req,
    output phase_e       phase,
    output logic         accept
);

    phase_e phase_q;
    phase_e phase_nx;

    // Next-phase decision; hold beats halt beats a new request.
    always_comb begin
        accept   = 1'b0;
        phase_nx = phase_q;
        case (phase_q)
            PH_T1:  phase_nx = PH_T2;
            PH_T2:  phase_nx = PH_T3;
            PH_T3:  phase_nx = PH_IDLE;
            PH_RST: phase_nx = PH_IDLE;
            default: begin
                if (hold_req) begin
                    phase_nx = PH_HOLD;
                end else if (halt_req) begin
                    phase_nx = PH_HALT;
                end else if (req_valid && kind_ok(req_kind)) begin
                    phase_nx = PH_T1;
                    accept   = 1'b1;
                end else begin
                    phase_nx = PH_IDLE;
                end
            end
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_RST;
        else        phase_q <= phase_nx;
    end

    assign phase = phase_q;

    // R1
    accept_starts_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase_q == PH_T1));

    // R1
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_T1) |=> (phase_q == PH_T2));

    // R1
    t3_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_T3) |=> (phase_q == PH_IDLE));

    // R10
    hold_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_T2) && hold_req) |=> (phase_q == PH_T3));

    // R11
    bad_kind_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kind_ok(req_kind)) |-> !accept);

    // R7
    no_accept_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> !accept);

endmodule

// File: rtl/bcc_req_regs.sv
// Request and read-data registers: holds the accepted cycle's kind, address
// and write data, and captures the shared lines at the edge that ends T3.
// Assumes: accept is only high when the sequencer is between cycles.
module bcc_req_regs
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] ad_in,
    output logic [2:0]        cur_kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    logic capture;

    // Read data is taken on the edge that leaves T3 of a read-type cycle.
    always_comb capture = (phase == PH_T3) && kind_reads(cur_kind);

    // Latch the request fields when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= K_NONE;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_kind  <= req_kind;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    // Capture read data and flag it for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= capture;
            if (capture) rdata <= ad_in;
        end
    end

    // R5
    rdata_after_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (phase == PH_IDLE));

    // R1
    fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2) |-> $stable(cur_addr) && $stable(cur_kind));

endmodule

// File: rtl/bcc_pin_drive.sv
// Pin decoder: turns the phase and the latched request into pin values and
// output enables for the pad ring.
// Assumes: an enable of 0 means the pad floats; values under a 0 enable are
// don't-care and held at a fixed level here.
module bcc_pin_drive
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase,
    input  logic [2:0]               cur_kind,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [DATA_W-1:0]        cur_wdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_hi_oe,
    output logic                     ale,
    output logic                     iom,
    output logic                     s1,
    output logic                     s0,
    output logic                     iom_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     ctl_oe,
    output logic                     inta_n,
    output logic                     busy
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic in_cycle;
    logic data_phase;
    logic [2:0] status;

    // Cycle and data-phase flags.
    always_comb begin
        in_cycle   = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_T3);
        data_phase = (phase == PH_T2) || (phase == PH_T3);
    end

    // Address, status and enable decode by phase.
    always_comb begin
        ale        = 1'b0;
        ad_oe      = 1'b0;
        ad_out     = '0;
        addr_hi    = cur_addr[ADDR_W-1 -: HI_W];
        addr_hi_oe = 1'b0;
        status     = 3'b000;
        iom_oe     = 1'b0;
        ctl_oe     = 1'b0;
        case (phase)
            PH_IDLE, PH_T1, PH_T2, PH_T3: begin
                addr_hi_oe = 1'b1;
                status     = cur_kind;
                iom_oe     = 1'b1;
                ctl_oe     = 1'b1;
                if (phase == PH_T1) begin
                    ale    = 1'b1;
                    ad_oe  = 1'b1;
                    ad_out = cur_addr[DATA_W-1:0];
                end else if (data_phase && kind_writes(cur_kind)) begin
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                end
            end
            PH_HALT: ctl_oe = 1'b1;
            default: ctl_oe = 1'b0;
        endcase
    end

    // Strobes are active only in the data phase of a matching cycle.
    always_comb begin
        rd_n   = !(data_phase && kind_rd_strobe(cur_kind));
        wr_n   = !(data_phase && kind_writes(cur_kind));
        inta_n = !(data_phase && (cur_kind == K_INTA));
    end

    assign iom  = status[2];
    assign s1   = status[1];
    assign s0   = status[0];
    assign busy = in_cycle;

    // R1
    ale_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R2
    ale_with_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && addr_hi_oe && busy));

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctl_oe & ~rd_n, ctl_oe & ~wr_n, ~inta_n}) <= 1);

    // R5
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !wr_n) |-> ad_oe);

    // R5
    read_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_oe && !rd_n) || !inta_n) |-> !ad_oe);

    // R7
    floated_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hi_oe |-> (!ad_oe && !busy && inta_n && !ale));

    // R8
    halt_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iom_oe && ctl_oe) |-> (rd_n && wr_n && !s1 && !s0));

endmodule

// File: rtl/bus_cycle_ctrl.sv
// Bus cycle controller top: runs one three-clock machine cycle per accepted
// request on a multiplexed low address/data bus plus an upper address bus,
// and floats selected pins in hold, halt and reset.
// Assumes: pads build tristates from the value/enable pairs.
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     hold_req,
    input  logic                     halt_req,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     addr_hi_oe,
    output logic                     ale,
    output logic                     iom,
    output logic                     s1,
    output logic                     s0,
    output logic                     iom_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     ctl_oe,
    output logic                     inta_n,
    output logic                     busy,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid
);

    phase_e            phase;
    logic              accept;
    logic [2:0]        cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    bcc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .hold_req  (hold_req),
        .halt_req  (halt_req),
        .phase     (phase),
        .accept    (accept)
    );

    bcc_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .ad_in       (ad_in),
        .cur_kind    (cur_kind),
        .cur_addr    (cur_addr),
        .cur_wdata   (cur_wdata),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    bcc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cur_kind   (cur_kind),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .addr_hi    (addr_hi),
        .addr_hi_oe (addr_hi_oe),
        .ale        (ale),
        .iom        (iom),
        .s1         (s1),
        .s0         (s0),
        .iom_oe     (iom_oe),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ctl_oe     (ctl_oe),
        .inta_n     (inta_n),
        .busy       (busy)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (inta_n && !iom_oe && !addr_hi_oe && !ad_oe && !ctl_oe && !busy));

endmodule

// File: tb/sim_bus_cycle_ctrl.sv
module sim_bus_cycle_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'b000;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       hold_req = 1'b0;
    logic       halt_req = 1'b0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] addr_hi;
    logic       addr_hi_oe, ale, iom, s1, s0, iom_oe, rd_n, wr_n, ctl_oe, inta_n, busy;
    logic [7:0] rdata;
    logic       rdata_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    bus_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .hold_req(hold_req),
        .halt_req(halt_req), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ale(ale), .iom(iom),
        .s1(s1), .s0(s0), .iom_oe(iom_oe), .rd_n(rd_n), .wr_n(wr_n),
        .ctl_oe(ctl_oe), .inta_n(inta_n), .busy(busy), .rdata(rdata),
        .rdata_valid(rdata_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference model: 0 idle, 1..3 T1..T3, 4 hold, 5 halt, 6 reset.
    int         m_ph = -1;
    logic [2:0] m_kind;
    logic [15:0] m_addr;
    logic [7:0] m_wd, m_rd;
    logic       m_rv;

    function automatic bit legal(input logic [2:0] k);
        return !(k == 3'b000 || k == 3'b100);
    endfunction
    function automatic bit rd_kind(input logic [2:0] k);
        return k == 3'b011 || k == 3'b010 || k == 3'b110;
    endfunction
    function automatic bit wr_kind(input logic [2:0] k);
        return k == 3'b001 || k == 3'b101;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 6; m_kind = 3'b000; m_addr = '0; m_wd = '0; m_rd = '0; m_rv = 1'b0;
        end else if (m_ph >= 0) begin
            m_rv = (m_ph == 3) && (rd_kind(m_kind) || m_kind == 3'b111);
            if (m_rv) m_rd = ad_in;
            if (m_ph == 1 || m_ph == 2) m_ph = m_ph + 1;
            else if (m_ph == 3 || m_ph == 6) m_ph = 0;
            else if (hold_req) m_ph = 4;
            else if (halt_req) m_ph = 5;
            else if (req_valid && legal(req_kind)) begin
                m_ph = 1; m_kind = req_kind; m_addr = req_addr; m_wd = req_wdata;
            end else m_ph = 0;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        logic e_ale, e_busy, e_adoe, e_hioe, e_iomoe, e_ctloe, e_rd, e_wr, e_inta;
        logic [7:0] e_ad;
        logic [2:0] e_stat;
        string t1, t2, t3, t4, t5;
        if (m_ph >= 0 && !done) begin
            e_ale = 0; e_busy = 0; e_adoe = 0; e_ad = '0; e_hioe = 0; e_iomoe = 0;
            e_stat = 3'b000; e_ctloe = 0; e_rd = 1; e_wr = 1; e_inta = 1;
            t1 = "R1"; t2 = "R2"; t3 = "R6"; t4 = "R3"; t5 = "R4";
            case (m_ph)
                0: begin e_hioe = 1; e_iomoe = 1; e_stat = m_kind; e_ctloe = 1; end
                1, 2, 3: begin
                    e_busy = 1; e_hioe = 1; e_iomoe = 1; e_stat = m_kind; e_ctloe = 1;
                    if (m_ph == 1) begin
                        e_ale = 1; e_adoe = 1; e_ad = m_addr[7:0];
                    end else begin
                        t2 = "R5";
                        e_adoe = wr_kind(m_kind); e_ad = m_wd;
                        e_rd = !rd_kind(m_kind); e_wr = !wr_kind(m_kind);
                        e_inta = !(m_kind == 3'b111);
                    end
                end
                4: begin t1 = "R7"; t2 = "R7"; t3 = "R7"; t4 = "R7"; t5 = "R7"; end
                5: begin e_ctloe = 1; t1 = "R8"; t2 = "R8"; t3 = "R8"; t4 = "R8"; t5 = "R8"; end
                default: begin t1 = "R9"; t2 = "R9"; t3 = "R9"; t4 = "R9"; t5 = "R9"; end
            endcase
            chk(t1, {30'd0, ale, busy}, {30'd0, e_ale, e_busy});
            chk(t2, {23'd0, ad_oe, (e_adoe ? ad_out : 8'h00)}, {23'd0, e_adoe, e_ad & {8{e_adoe}}});
            chk(t3, {23'd0, addr_hi_oe, (e_hioe ? addr_hi : 8'h00)},
                {23'd0, e_hioe, (e_hioe ? m_addr[15:8] : 8'h00)});
            chk(t4, {28'd0, iom_oe, (e_iomoe ? iom : 1'b0), s1, s0},
                {28'd0, e_iomoe, e_stat[2] & e_iomoe, e_stat[1:0]});
            chk(t5, {28'd0, ctl_oe, (e_ctloe ? rd_n : 1'b0), (e_ctloe ? wr_n : 1'b0), inta_n},
                {28'd0, e_ctloe, e_rd & e_ctloe, e_wr & e_ctloe, e_inta});
            chk("R5", {23'd0, rdata_valid, rdata}, {23'd0, m_rv, m_rd});
        end
    end

    // New read data value on the shared lines every clock.
    always @(negedge clk) ad_in <= ad_in + 8'h3B;

    task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        chk("R9", {28'd0, inta_n, iom_oe, addr_hi_oe, busy}, {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5: one cycle of every kind
        issue(3'b011, 16'h1234, 8'h00);
        issue(3'b010, 16'hFFFF, 8'h00);
        issue(3'b001, 16'h0000, 8'hA5);
        issue(3'b110, 16'hA55A, 8'h00);
        issue(3'b101, 16'h80FE, 8'h5A);
        issue(3'b111, 16'h7F01, 8'h00);

        // R1: request held valid across several cycles
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'b001; req_addr = 16'hC3C3; req_wdata = 8'h11;
        repeat (9) @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R11: unused kind codes
        req_valid = 1'b1; req_kind = 3'b000;
        repeat (2) @(negedge clk);
        chk("R11", {30'd0, busy, ale}, 32'd0);
        req_kind = 3'b100;
        repeat (2) @(negedge clk);
        chk("R11", {30'd0, busy, ale}, 32'd0);
        req_valid = 1'b0;
        @(negedge clk);

        // R10: hold raised in T1 waits for the cycle to finish
        req_valid = 1'b1; req_kind = 3'b011; req_addr = 16'h4321;
        @(negedge clk);
        req_valid = 1'b0; hold_req = 1'b1;
        @(negedge clk);
        chk("R10", {30'd0, busy, rd_n}, {30'd0, 1'b1, 1'b0});
        req_valid = 1'b1; req_kind = 3'b010; req_addr = 16'h9999;
        repeat (4) @(negedge clk);
        // R7: request ignored, bus floated
        chk("R7", {29'd0, busy, addr_hi_oe, ctl_oe}, 32'd0);
        req_valid = 1'b0; hold_req = 1'b0;
        repeat (2) @(negedge clk);

        // R10: hold wins over halt
        hold_req = 1'b1; halt_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", {31'd0, ctl_oe}, 32'd0);
        hold_req = 1'b0;
        repeat (3) @(negedge clk);
        // R8: halt levels
        chk("R8", {28'd0, ctl_oe, rd_n, wr_n, iom_oe}, {28'd0, 1'b1, 1'b1, 1'b1, 1'b0});
        halt_req = 1'b0;
        repeat (2) @(negedge clk);

        // R9: reset in T2 of a write abandons it
        req_valid = 1'b1; req_kind = 3'b101; req_addr = 16'h2468; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", {29'd0, busy, ad_oe, inta_n}, {29'd0, 1'b0, 1'b0, 1'b1});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(3'b010, 16'h1357, 8'h00);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule